// File: doc/BRIEF.md
# UART Idle and Break Line Monitor

This block sits next to a UART receiver and watches the line one received character at a time. It has no view of serial samples. It receives a strobe for each finished character, the data bits of that character, and a flag that marks the character as a break character (all zeros including the stop position). It also receives a flag that says whether a receive buffer is currently being filled.

Two functions run in parallel. The idle function counts consecutive all-ones characters against a programmable limit. When the limit is reached, it closes the open buffer. The break function detects break sequences, counts them, measures their length in character times, and reports the end of each break when the line returns to one. A synchronous zero-stop mode guards against false breaks: in that mode a break is declared only after two break characters in a row.

Top module: `uart_line_monitor`

## Requirements
- R1: A character with `chrBreak`=0 and all `chrData` bits set to one is an idle character and advances an internal idle count. Any other character, including a break character, returns the idle count to zero.
- R2: With `idleMax`=N (N>0) and a buffer open, the Nth consecutive idle character makes `idleClose` pulse high for one cycle, in the cycle after that character's `chrValid` cycle. The idle count then restarts from zero, so the next close needs N more idle characters.
- R3: `rxIrq` pulses together with `idleClose` or `breakClose` when `rxIrqEn`=1. It stays low when `rxIrqEn`=0, while the close strobes still pulse.
- R4: When the idle limit is reached while `bufOpen`=0, neither `idleClose` nor `rxIrq` pulses, and the idle count still restarts from zero.
- R5: `idleMax`=0 turns the idle function off, so no number of idle characters produces `idleClose`.
- R6: When a break is declared, `brkCount` rises by one in the following cycle. It saturates at its all-ones value.
- R7: When a break is declared while `bufOpen`=1, `breakClose` pulses for one cycle in the following cycle. When `bufOpen`=0, it does not pulse.
- R8: The length of a break is the number of consecutive break characters it spans. That length is written to `brkLen` when the first non-break character arrives afterwards, and it saturates at the all-ones value of `brkLen`.
- R9: The first non-break character after a declared break makes `brkEvent` pulse for one cycle. `brkIrq` pulses with it only when `brkIrqEn`=1.
- R10: With `syncZeroStop`=1, a single break character followed by a non-break character changes neither `brkCount` nor `brkLen` and produces no close and no event. Two consecutive break characters declare the break at the second one, and the measured length includes both characters.
- R11: After reset, all strobes and interrupt outputs are low, and `brkCount` and `brkLen` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chrValid | input | 1 | One-cycle strobe for each received character |
| chrData | input | DATA_W | Data bits of the received character |
| chrBreak | input | 1 | Received character is a break character |
| bufOpen | input | 1 | A receive buffer is currently open |
| syncZeroStop | input | 1 | Synchronous zero-stop mode: two break characters needed |
| idleMax | input | IDLE_W | Idle character limit, 0 turns the idle function off |
| rxIrqEn | input | 1 | Enables the receive interrupt |
| brkIrqEn | input | 1 | Enables the break-end interrupt |
| idleClose | output | 1 | Buffer close due to the idle limit |
| breakClose | output | 1 | Buffer close due to a break during reception |
| rxIrq | output | 1 | Receive interrupt pulse |
| brkEvent | output | 1 | Line returned to one after a break |
| brkIrq | output | 1 | Break-end interrupt pulse |
| brkCount | output | CNT_W | Saturating count of declared breaks |
| brkLen | output | LEN_W | Length of the last completed break in characters |

## Verification
Saturation is the hardest state to reach from the ports. With 16-bit counters, the bench would need tens of thousands of break sequences. The bench therefore instantiates the block with narrow break-count and break-length widths and drives 20 break sequences and a 20-character break, which pushes both registers past their limits. The second difficult case is the pending state of synchronous zero-stop mode. The bench enters it with a lone break character and leaves it with an ordinary character. It then checks that count, length, close and event all stay unchanged before it sends a real two-character break.

// File: rtl/uart_line_monitor_pkg.sv
package uart_line_monitor_pkg;

  typedef enum logic [1:0] {
    LINE_NORMAL = 2'd0,
    LINE_PEND   = 2'd1,
    LINE_BREAK  = 2'd2
  } lineState_t;

  typedef struct packed {
    logic incIdle;   // idle character seen
    logic clrIdle;   // non-idle character seen
    logic brkDecl;   // break declared on this character
    logic lenFrom2;  // declared on second character
    logic lenInc;    // break continues
    logic brkEnd;    // line back to one
  } lineStrobe_t;

endpackage

// File: rtl/uart_line_monitor_ctrl.sv
module uart_line_monitor_ctrl
  import uart_line_monitor_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chrValid,
  input  logic [DATA_W-1:0] chrData,
  input  logic              chrBreak,
  input  logic              syncZeroStop,
  output lineStrobe_t       stb
);

  lineState_t state, stateNext;
  logic isIdle;

  assign isIdle = !chrBreak && (&chrData);

  always_comb begin
    stb       = '0;
    stateNext = state;
    if (chrValid) begin
      stb.incIdle = isIdle;
      stb.clrIdle = !isIdle;
      unique case (state)
        LINE_NORMAL: begin
          if (chrBreak) begin
            if (syncZeroStop) begin
              stateNext = LINE_PEND;
            end else begin
              stb.brkDecl = 1'b1;
              stateNext   = LINE_BREAK;
            end
          end
        end
        LINE_PEND: begin
          if (chrBreak) begin
            stb.brkDecl  = 1'b1;
            stb.lenFrom2 = 1'b1;
            stateNext    = LINE_BREAK;
          end else begin
            stateNext = LINE_NORMAL;
          end
        end
        LINE_BREAK: begin
          if (chrBreak) begin
            stb.lenInc = 1'b1;
          end else begin
            stb.brkEnd = 1'b1;
            stateNext  = LINE_NORMAL;
          end
        end
        default: stateNext = LINE_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= LINE_NORMAL;
    else       state <= stateNext;
  end

endmodule

// File: rtl/uart_line_monitor_dpath.sv
module uart_line_monitor_dpath
  import uart_line_monitor_pkg::*;
#(
  parameter int IDLE_W = 16,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineStrobe_t       stb,
  input  logic              bufOpen,
  input  logic [IDLE_W-1:0] idleMax,
  input  logic              rxIrqEn,
  input  logic              brkIrqEn,
  output logic              idleClose,
  output logic              breakClose,
  output logic              rxIrq,
  output logic              brkEvent,
  output logic              brkIrq,
  output logic [CNT_W-1:0]  brkCount,
  output logic [LEN_W-1:0]  brkLen
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_TWO = LEN_W'(2);

  logic [IDLE_W-1:0] idleCnt;
  logic [LEN_W-1:0]  lenCnt;
  logic [IDLE_W:0]   idleNext;
  logic              idleHit;
  logic              idleCloseNext;
  logic              breakCloseNext;

  assign idleNext       = {1'b0, idleCnt} + 1'b1;
  assign idleHit        = stb.incIdle && (idleMax != '0) && (idleNext >= {1'b0, idleMax});
  assign idleCloseNext  = idleHit && bufOpen;
  assign breakCloseNext = stb.brkDecl && bufOpen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt    <= '0;
      lenCnt     <= '0;
      brkCount   <= '0;
      brkLen     <= '0;
      idleClose  <= 1'b0;
      breakClose <= 1'b0;
      rxIrq      <= 1'b0;
      brkEvent   <= 1'b0;
      brkIrq     <= 1'b0;
    end else begin
      idleClose  <= idleCloseNext;
      breakClose <= breakCloseNext;
      rxIrq      <= rxIrqEn && (idleCloseNext || breakCloseNext);
      brkEvent   <= stb.brkEnd;
      brkIrq     <= stb.brkEnd && brkIrqEn;

      if (stb.clrIdle)      idleCnt <= '0;
      else if (idleHit)     idleCnt <= '0;
      else if (stb.incIdle) idleCnt <= idleNext[IDLE_W-1:0];

      if (stb.brkDecl) begin
        if (brkCount != CNT_MAX) brkCount <= brkCount + 1'b1;
        lenCnt <= stb.lenFrom2 ? LEN_TWO : LEN_ONE;
      end else if (stb.lenInc && (lenCnt != LEN_MAX)) begin
        lenCnt <= lenCnt + 1'b1;
      end

      if (stb.brkEnd) brkLen <= lenCnt;
    end
  end

endmodule

// File: rtl/uart_line_monitor.sv
module uart_line_monitor
  import uart_line_monitor_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDLE_W = 16,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chrValid,
  input  logic [DATA_W-1:0] chrData,
  input  logic              chrBreak,
  input  logic              bufOpen,
  input  logic              syncZeroStop,
  input  logic [IDLE_W-1:0] idleMax,
  input  logic              rxIrqEn,
  input  logic              brkIrqEn,
  output logic              idleClose,
  output logic              breakClose,
  output logic              rxIrq,
  output logic              brkEvent,
  output logic              brkIrq,
  output logic [CNT_W-1:0]  brkCount,
  output logic [LEN_W-1:0]  brkLen
);

  lineStrobe_t stb;

  uart_line_monitor_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .chrValid     (chrValid),
    .chrData      (chrData),
    .chrBreak     (chrBreak),
    .syncZeroStop (syncZeroStop),
    .stb          (stb)
  );

  uart_line_monitor_dpath #(.IDLE_W(IDLE_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .bufOpen    (bufOpen),
    .idleMax    (idleMax),
    .rxIrqEn    (rxIrqEn),
    .brkIrqEn   (brkIrqEn),
    .idleClose  (idleClose),
    .breakClose (breakClose),
    .rxIrq      (rxIrq),
    .brkEvent   (brkEvent),
    .brkIrq     (brkIrq),
    .brkCount   (brkCount),
    .brkLen     (brkLen)
  );

endmodule

// File: rtl/uart_line_monitor_chk.sv
module uart_line_monitor_chk #(
  parameter int DATA_W = 8,
  parameter int IDLE_W = 16,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              chrValid,
  input logic [DATA_W-1:0] chrData,
  input logic              chrBreak,
  input logic              bufOpen,
  input logic              syncZeroStop,
  input logic [IDLE_W-1:0] idleMax,
  input logic              rxIrqEn,
  input logic              brkIrqEn,
  input logic              idleClose,
  input logic              breakClose,
  input logic              rxIrq,
  input logic              brkEvent,
  input logic              brkIrq,
  input logic [CNT_W-1:0]  brkCount,
  input logic [LEN_W-1:0]  brkLen
);

  AST_IDLE_NEEDS_BUF: assert property (@(posedge clk) disable iff (!rstN)
    idleClose |-> $past(bufOpen) && $past(chrValid)); // R4
  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    idleClose |-> $past(idleMax) != '0); // R5
  AST_RXIRQ_SRC: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> (idleClose || breakClose) && $past(rxIrqEn)); // R3
  AST_BRKCNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (brkCount == $past(brkCount)) || (brkCount == $past(brkCount) + 1'b1)); // R6
  AST_BRKCLOSE_NEEDS_BUF: assert property (@(posedge clk) disable iff (!rstN)
    breakClose |-> $past(bufOpen) && $past(chrBreak)); // R7
  AST_BRKEVT_LEN: assert property (@(posedge clk) disable iff (!rstN)
    brkEvent |-> (brkLen != '0) && $past(chrValid) && !$past(chrBreak)); // R8
  AST_BRKIRQ_EVT: assert property (@(posedge clk) disable iff (!rstN)
    brkIrq |-> brkEvent); // R9
  AST_CLOSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(idleClose && breakClose)); // R1

endmodule

bind uart_line_monitor uart_line_monitor_chk #(
  .DATA_W(DATA_W), .IDLE_W(IDLE_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/uart_line_monitor_tb.sv
module uart_line_monitor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int IDLE_W = 16;
  localparam int CNT_W  = 4;
  localparam int LEN_W  = 4;

  logic clk = 1'b0;
  logic rstN;
  logic chrValid;
  logic [DATA_W-1:0] chrData;
  logic chrBreak;
  logic bufOpen;
  logic syncZeroStop;
  logic [IDLE_W-1:0] idleMax;
  logic rxIrqEn;
  logic brkIrqEn;
  logic idleClose, breakClose, rxIrq, brkEvent, brkIrq;
  logic [CNT_W-1:0] brkCount;
  logic [LEN_W-1:0] brkLen;

  int nChecks = 0;
  int nFails  = 0;
  int expCnt  = 0;
  bit done    = 0;

  logic sIdleClose, sBreakClose, sRxIrq, sBrkEvent, sBrkIrq;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_line_monitor #(.DATA_W(DATA_W), .IDLE_W(IDLE_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rstN(rstN), .chrValid(chrValid), .chrData(chrData), .chrBreak(chrBreak),
    .bufOpen(bufOpen), .syncZeroStop(syncZeroStop), .idleMax(idleMax),
    .rxIrqEn(rxIrqEn), .brkIrqEn(brkIrqEn), .idleClose(idleClose), .breakClose(breakClose),
    .rxIrq(rxIrq), .brkEvent(brkEvent), .brkIrq(brkIrq), .brkCount(brkCount), .brkLen(brkLen)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one character; capture the registered strobes one cycle later.
  task automatic sendChr(input logic [DATA_W-1:0] d, input logic brk);
    @(negedge clk);
    chrValid = 1'b1; chrData = d; chrBreak = brk;
    @(negedge clk);
    chrValid = 1'b0; chrBreak = 1'b0; chrData = '0;
    sIdleClose = idleClose; sBreakClose = breakClose; sRxIrq = rxIrq;
    sBrkEvent = brkEvent; sBrkIrq = brkIrq;
  endtask

  task automatic sendIdle();   sendChr(8'hFF, 1'b0); endtask
  task automatic sendNormal(); sendChr(8'h41, 1'b0); endtask
  task automatic sendBreak();  sendChr(8'h00, 1'b1); endtask

  task automatic t_reset();
    check("R11", "idleClose", idleClose, 0);
    check("R11", "breakClose", breakClose, 0);
    check("R11", "rxIrq", rxIrq, 0);
    check("R11", "brkEvent", brkEvent, 0);
    check("R11", "brkIrq", brkIrq, 0);
    check("R11", "brkCount", brkCount, 0);
    check("R11", "brkLen", brkLen, 0);
  endtask

  task automatic t_idleBasic();
    bufOpen = 1; rxIrqEn = 1; idleMax = 3;
    sendNormal();
    sendIdle(); sendIdle(); sendNormal();
    check("R1", "non-idle clears count", sIdleClose, 0);
    sendIdle(); sendIdle();
    check("R1", "two idle after clear", sIdleClose, 0);
    sendIdle();
    check("R2", "idleClose at limit", sIdleClose, 1);
    check("R3", "rxIrq with idle close", sRxIrq, 1);
    sendIdle(); sendIdle();
    check("R2", "no close right after restart", sIdleClose, 0);
    sendIdle();
    check("R2", "close after restart", sIdleClose, 1);
  endtask

  task automatic t_breakClearsIdle();
    bufOpen = 1; rxIrqEn = 1; idleMax = 3; syncZeroStop = 0; brkIrqEn = 1;
    sendNormal();
    sendIdle(); sendIdle();
    sendBreak(); expCnt++;
    sendNormal();
    sendIdle(); sendIdle();
    check("R1", "break char clears idle count", sIdleClose, 0);
    sendIdle();
    check("R1", "limit after break clear", sIdleClose, 1);
  endtask

  task automatic t_idleNoBuf();
    rxIrqEn = 1; idleMax = 3;
    sendNormal();
    bufOpen = 0;
    sendIdle(); sendIdle(); sendIdle();
    check("R4", "no idleClose without buffer", sIdleClose, 0);
    check("R4", "no rxIrq without buffer", sRxIrq, 0);
    bufOpen = 1;
    sendIdle(); sendIdle();
    check("R4", "count restarted", sIdleClose, 0);
    sendIdle();
    check("R4", "close after restart", sIdleClose, 1);
  endtask

  task automatic t_idleMasked();
    bufOpen = 1; rxIrqEn = 0; idleMax = 2;
    sendNormal();
    sendIdle(); sendIdle();
    check("R3", "close with irq masked", sIdleClose, 1);
    check("R3", "rxIrq masked", sRxIrq, 0);
  endtask

  task automatic t_idleDisabled();
    int closes = 0;
    bufOpen = 1; rxIrqEn = 1; idleMax = 0;
    sendNormal();
    for (int i = 0; i < 10; i++) begin
      sendIdle();
      if (sIdleClose) closes++;
    end
    check("R5", "idle limit zero never closes", closes, 0);
  endtask

  task automatic t_asyncBreak();
    bufOpen = 1; rxIrqEn = 1; brkIrqEn = 1; syncZeroStop = 0; idleMax = 0;
    sendNormal();
    sendBreak(); expCnt++;
    check("R6", "brkCount incremented", brkCount, expCnt);
    check("R7", "breakClose with buffer", sBreakClose, 1);
    check("R3", "rxIrq with break close", sRxIrq, 1);
    sendBreak(); sendBreak();
    check("R9", "no event during break", sBrkEvent, 0);
    check("R6", "count once per break", brkCount, expCnt);
    sendNormal();
    check("R9", "brkEvent on return", sBrkEvent, 1);
    check("R9", "brkIrq enabled", sBrkIrq, 1);
    check("R8", "brkLen three", brkLen, 3);
  endtask

  task automatic t_breakNoBuf();
    bufOpen = 0; rxIrqEn = 1; brkIrqEn = 0; syncZeroStop = 0;
    sendNormal();
    sendBreak(); expCnt++;
    check("R7", "no breakClose without buffer", sBreakClose, 0);
    check("R6", "count still increments", brkCount, expCnt);
    sendNormal();
    check("R9", "event with irq masked", sBrkEvent, 1);
    check("R9", "brkIrq masked", sBrkIrq, 0);
    check("R8", "brkLen one", brkLen, 1);
  endtask

  task automatic t_syncMode();
    int prevLen;
    bufOpen = 1; rxIrqEn = 1; brkIrqEn = 1; syncZeroStop = 1;
    sendNormal();
    prevLen = int'(brkLen);
    sendBreak();
    check("R10", "single break no close", sBreakClose, 0);
    check("R10", "single break no count", brkCount, expCnt);
    sendNormal();
    check("R10", "no event after lone break", sBrkEvent, 0);
    check("R10", "brkLen kept", brkLen, prevLen);
    sendBreak(); sendBreak(); expCnt++;
    check("R10", "declared at second break", sBreakClose, 1);
    check("R10", "count after two", brkCount, expCnt);
    sendBreak(); sendNormal();
    check("R10", "event after sync break", sBrkEvent, 1);
    check("R10", "length includes both", brkLen, 3);
    syncZeroStop = 0;
  endtask

  task automatic t_lenSat();
    bufOpen = 0; syncZeroStop = 0;
    sendNormal();
    for (int i = 0; i < 20; i++) sendBreak();
    expCnt++;
    sendNormal();
    check("R8", "brkLen saturates", brkLen, 15);
  endtask

  task automatic t_cntSat();
    bufOpen = 0; syncZeroStop = 0;
    for (int i = 0; i < 20; i++) begin
      sendBreak(); sendNormal();
      if (expCnt < 15) expCnt++;
    end
    check("R6", "brkCount saturates", brkCount, 15);
  endtask

  initial begin
    rstN = 0; chrValid = 0; chrData = '0; chrBreak = 0; bufOpen = 0;
    syncZeroStop = 0; idleMax = '0; rxIrqEn = 0; brkIrqEn = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_idleBasic();
    t_breakClearsIdle();
    t_idleNoBuf();
    t_idleMasked();
    t_idleDisabled();
    t_asyncBreak();
    t_breakNoBuf();
    t_syncMode();
    t_lenSat();
    t_cntSat();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule